// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block compares two unsigned operands of a configurable width and reports whether the first is greater than, less than, or equal to the second. It is a chain of identical comparison cells. A two-wire status (greater, less) enters at the most significant position and leaves at the least significant one. Each cell either passes on an ordering that a higher position has already settled, or, while the operands are still equal, settles the ordering from its own bits.

A parameter chooses the cell size. One-bit cells give one stage per bit. Two-bit cells resolve a bit pair per stage, which halves the number of stages the status crosses. When the width is odd and two-bit cells are chosen, a lone one-bit cell handles bit 0. The block is purely combinational.

The chain-in pair lets several instances be joined: tie both to 0 for a standalone compare, or feed them from a more significant comparator. An equal flag is derived from the final status.

Top module: `magcmp_ripple`

## Requirements
- R1: With both chain inputs at 0, `gt_o` is 1 exactly when `a_i` > `b_i` (unsigned), for every operand pair.
- R2: With both chain inputs at 0, `lt_o` is 1 exactly when `a_i` < `b_i` (unsigned), for every operand pair.
- R3: `gt_o` and `lt_o` are never 1 at the same time, whenever the chain inputs are not both 1.
- R4: With `gt_in`=1 and `lt_in`=0, the result is `gt_o`=1 and `lt_o`=0 whatever the operands.
- R5: With `lt_in`=1 and `gt_in`=0, the result is `lt_o`=1 and `gt_o`=0 whatever the operands.
- R6: `eq_o` is 1 exactly when `gt_o` and `lt_o` are both 0. With both chain inputs at 0, this is exactly when `a_i` == `b_i`.
- R7: Two-bit cells (`RADIX`=2), including an odd width whose bit 0 uses a one-bit cell, give the same outputs as one-bit cells (`RADIX`=1) for every input.
- R8: The most significant differing bit decides the result: if `a_i` and `b_i` first differ at bit k, the bits below k have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_in | input | 1 | Chain-in: a more significant stage found a > b |
| lt_in | input | 1 | Chain-in: a more significant stage found a < b |
| gt_o | output | 1 | Result: a > b |
| lt_o | output | 1 | Result: a < b |
| eq_o | output | 1 | Result: a == b (neither greater nor less) |

## Verification
The block holds no state, so a faulty cell or a miswired stage shows at the outputs as soon as the inputs settle. It shows only for operand pairs whose most significant difference lies in that cell's bit positions, or for pairs equal down to that cell. Small widths are therefore swept over every operand pair with each chain-in value, so every cell decides at least once. A wide odd-width instance gets random pairs plus pairs built to differ only at one chosen bit. The one-bit and two-bit variants are also compared against each other on the same inputs.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
   typedef struct packed {
      logic gt;
      logic lt;
   } ord_t;

   localparam ord_t ORD_EQ = '{gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/magcmp_cell1.sv
module magcmp_cell1
   import magcmp_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   input  ord_t up_i,
   output ord_t dn_o
);
   logic undecided;

   always_comb begin
      undecided = ~up_i.gt & ~up_i.lt;
      dn_o.gt   = up_i.gt | (undecided & a_i & ~b_i);
      dn_o.lt   = up_i.lt | (undecided & ~a_i & b_i);
   end
endmodule

// File: rtl/magcmp_cell2.sv
module magcmp_cell2
   import magcmp_pkg::*;
(
   input  logic [1:0] a_i,
   input  logic [1:0] b_i,
   input  ord_t       up_i,
   output ord_t       dn_o
);
   logic undecided;
   logic hi_same;
   logic pair_gt;
   logic pair_lt;

   always_comb begin
      undecided = ~up_i.gt & ~up_i.lt;
      hi_same   = ~(a_i[1] ^ b_i[1]);
      pair_gt   = (a_i[1] & ~b_i[1]) | (hi_same & a_i[0] & ~b_i[0]);
      pair_lt   = (~a_i[1] & b_i[1]) | (hi_same & ~a_i[0] & b_i[0]);
      dn_o.gt   = up_i.gt | (undecided & pair_gt);
      dn_o.lt   = up_i.lt | (undecided & pair_lt);
   end
endmodule

// File: rtl/magcmp_ripple.sv
module magcmp_ripple
   import magcmp_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int RADIX = 2
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             gt_in,
   input  logic             lt_in,
   output logic             gt_o,
   output logic             lt_o,
   output logic             eq_o
);
   localparam int NPAIR  = WIDTH / 2;
   localparam int HASODD = WIDTH % 2;
   localparam int NSTG   = (RADIX == 2) ? (NPAIR + HASODD) : WIDTH;

   if (WIDTH < 1) begin : g_bad_width
      $error("magcmp_ripple: WIDTH must be at least 1");
   end
   if (RADIX != 1 && RADIX != 2) begin : g_bad_radix
      $error("magcmp_ripple: RADIX must be 1 or 2");
   end

   ord_t [NSTG:0] st;

   assign st[0] = '{gt: gt_in, lt: lt_in};

   if (RADIX == 2) begin : g_r2
      for (genvar j = 0; j < NPAIR; j++) begin : g_pair
         localparam int HI = WIDTH - 1 - 2 * j;
         magcmp_cell2 u_cell (
            .a_i  (a_i[HI -: 2]),
            .b_i  (b_i[HI -: 2]),
            .up_i (st[j]),
            .dn_o (st[j+1])
         );
      end
      if (HASODD == 1) begin : g_tail
         magcmp_cell1 u_cell (
            .a_i  (a_i[0]),
            .b_i  (b_i[0]),
            .up_i (st[NPAIR]),
            .dn_o (st[NPAIR+1])
         );
      end
   end else begin : g_r1
      for (genvar j = 0; j < WIDTH; j++) begin : g_bit
         magcmp_cell1 u_cell (
            .a_i  (a_i[WIDTH-1-j]),
            .b_i  (b_i[WIDTH-1-j]),
            .up_i (st[j]),
            .dn_o (st[j+1])
         );
      end
   end

   assign gt_o = st[NSTG].gt;
   assign lt_o = st[NSTG].lt;
   assign eq_o = ~(st[NSTG].gt | st[NSTG].lt);
endmodule

// File: rtl/magcmp_ripple_chk.sv
module magcmp_ripple_chk #(
   parameter int WIDTH = 9
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             gt_in,
   input logic             lt_in,
   input logic             gt_o,
   input logic             lt_o,
   input logic             eq_o
);
   always_comb begin
      if (!(gt_in && lt_in)) begin
         a_r3_never_both: assert (!(gt_o && lt_o));
      end
      if (gt_in && !lt_in) begin
         a_r4_pass_gt: assert (gt_o && !lt_o);
      end
      if (lt_in && !gt_in) begin
         a_r5_pass_lt: assert (lt_o && !gt_o);
      end
      if (!gt_in && !lt_in) begin
         a_r1_greater: assert (gt_o == (a_i > b_i));
         a_r2_less:    assert (lt_o == (a_i < b_i));
         a_r6_equal:   assert (eq_o == (a_i == b_i));
      end
   end
endmodule

bind magcmp_ripple magcmp_ripple_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_magcmp_ripple.sv
`timescale 1ns/1ps
module sim_magcmp_ripple;
   localparam int W0 = 9;
   localparam int WS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [W0-1:0] a0, b0;
   logic          gi0, li0, g0, l0, e0;
   logic [WS-1:0] as, bs;
   logic          gis, lis, g1, l1, e1, g2, l2, e2;

   magcmp_ripple #(.WIDTH(W0), .RADIX(2)) u0 (
      .a_i(a0), .b_i(b0), .gt_in(gi0), .lt_in(li0),
      .gt_o(g0), .lt_o(l0), .eq_o(e0));
   magcmp_ripple #(.WIDTH(WS), .RADIX(1)) u1 (
      .a_i(as), .b_i(bs), .gt_in(gis), .lt_in(lis),
      .gt_o(g1), .lt_o(l1), .eq_o(e1));
   magcmp_ripple #(.WIDTH(WS), .RADIX(2)) u2 (
      .a_i(as), .b_i(bs), .gt_in(gis), .lt_in(lis),
      .gt_o(g2), .lt_o(l2), .eq_o(e2));

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act(g,l,eq)=%b exp=%b", req, act, exp);
      end
   endtask

   function automatic logic [2:0] model(input longint a, input longint b,
                                        input logic gi, input logic li);
      logic g, l;
      if (gi)      begin g = 1'b1; l = 1'b0; end
      else if (li) begin g = 1'b0; l = 1'b1; end
      else         begin g = (a > b); l = (a < b); end
      return {g, l, ~(g | l)};
   endfunction

   function automatic string tag(input logic gi, input logic li, input logic [2:0] e);
      if (gi) return "R4";
      if (li) return "R5";
      if (e[2]) return "R1";
      if (e[1]) return "R2";
      return "R6";
   endfunction

   task automatic run_small(input logic gi, input logic li);
      for (int x = 0; x < (1 << WS); x++) begin
         for (int y = 0; y < (1 << WS); y++) begin
            logic [2:0] e;
            @(posedge clk);
            as = x[WS-1:0]; bs = y[WS-1:0]; gis = gi; lis = li;
            @(negedge clk);
            e = model(x, y, gi, li);
            chk({tag(gi, li, e), " radix1"}, {g1, l1, e1}, e);
            chk({tag(gi, li, e), " radix2"}, {g2, l2, e2}, e);
            chk("R7 radix2 vs radix1", {g2, l2, e2}, {g1, l1, e1});
            chk("R3 not both", {1'b0, g1 & l1, g2 & l2}, 3'b000);
         end
      end
   endtask

   task automatic run_wide(input logic [W0-1:0] a, input logic [W0-1:0] b,
                           input logic gi, input logic li, input string req);
      logic [2:0] e;
      @(posedge clk);
      a0 = a; b0 = b; gi0 = gi; li0 = li;
      @(negedge clk);
      e = model(a, b, gi, li);
      chk(req, {g0, l0, e0}, e);
      chk("R3 not both", {2'b00, g0 & l0}, 3'b000);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      a0 = '0; b0 = '0; gi0 = 1'b0; li0 = 1'b0;
      as = '0; bs = '0; gis = 1'b0; lis = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 idle equal", {g0, l0, e0}, 3'b001);

      run_small(1'b0, 1'b0);
      run_small(1'b1, 1'b0);
      run_small(1'b0, 1'b1);

      run_wide('1, '1, 1'b0, 1'b0, "R6 all ones");
      run_wide('1, '0, 1'b0, 1'b0, "R1 max vs zero");
      run_wide('0, '1, 1'b0, 1'b0, "R2 zero vs max");
      run_wide('0, '1, 1'b1, 1'b0, "R4 gt_in overrides");
      run_wide('1, '0, 1'b0, 1'b1, "R5 lt_in overrides");
      for (int k = 0; k < W0; k++) begin
         logic [W0-1:0] hi, lo1, lo2;
         hi  = W0'($urandom);
         lo1 = W0'($urandom);
         lo2 = W0'($urandom);
         for (int i = 0; i <= k; i++) begin
            lo1[i] = 1'b0; lo2[i] = 1'b0;
         end
         for (int i = k; i < W0; i++) begin
            lo1[i] = hi[i]; lo2[i] = hi[i];
         end
         lo1[k] = 1'b1; lo2[k] = 1'b0;
         for (int i = 0; i < k; i++) begin
            lo1[i] = 1'b0; lo2[i] = 1'b1;
         end
         run_wide(lo1, lo2, 1'b0, 1'b0, "R8 msb difference wins gt");
         run_wide(lo2, lo1, 1'b0, 1'b0, "R8 msb difference wins lt");
      end
      for (int n = 0; n < 3000; n++) begin
         logic [W0-1:0] ra, rb;
         ra = W0'($urandom);
         rb = (n % 4 == 0) ? ra : W0'($urandom);
         run_wide(ra, rb, 1'b0, 1'b0, "R1/R2 random odd width");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule